// File: doc/BRIEF.md
# Interval Counter Bank with Zero Detect

This block holds four interval counters. Each counter steps forward by one modify operation whenever its clock source produces a pulse. The clock sources are a line-frequency tick, a 500 Hz tick, a 2000 Hz tick and one external tick per selectable counter. The modify operation adds a small signed value to the counter. The add acts on a byte, a halfword or a full word, depending on the width set for that counter. When the part of the counter that was modified becomes zero, the block raises a one-cycle zero event for that counter. Every pulse from a counter's source also raises a one-cycle count-pulse strobe, which feeds the matching interrupt level.

Counters 0, 1 and 2 each have their own 2-bit source select. Counter 3 always runs from the 500 Hz tick. All tick inputs are asynchronous. Each one is synchronized and edge-detected, so that every rising edge causes one step and only one. A load port writes a counter's value and operand width directly. When a load and a step land on the same counter in the same cycle, the load wins.

Top module: `cpb_bank`

## Requirements
- R1: After a synchronous reset, every counter value is 0, every width is word, and all `pulse_irq` and `zero_irq` bits are 0.
- R2: Each low-to-high transition of a counter's selected source causes exactly one modify. The value changes on the third rising clock edge after the tick is first sampled high. Holding the tick high causes no further modify, and with no step and no load the value is stable.
- R3: For counters 0 to 2, `src_sel` field i (bits 2i+1:2i) selects the source: 0 selects line frequency, 1 selects 500 Hz, 2 selects 2000 Hz, and 3 selects `ext_tick[i]`. Ticks on unselected sources have no effect on that counter.
- R4: Counter 3 steps only on the 500 Hz tick, whatever `src_sel`, `line_tick`, `tick_2000` or `ext_tick` do.
- R5: `pulse_irq[i]` is high for exactly one cycle, in the cycle that the step's modify would take effect, for every selected source edge. This holds even when a load displaces the modify.
- R6: The modify value is a signed 4-bit field, `delta` bits 4i+3:4i, sign-extended to the operand width. The width encoding is 0 byte, 1 halfword, 2 word and 3 word. In byte mode only bits 7:0 change, and they wrap modulo 256.
- R7: In halfword mode only bits 15:0 change, and they wrap modulo 65536. In word mode all 32 bits change, and they wrap modulo 2^32.
- R8: `zero_irq[i]` pulses for one cycle when the selected-width field of counter i is zero after a modify. Nonzero bits above the field do not suppress it, and other counters are unaffected.
- R9: A high `load_en[i]` writes `load_val` and `load_width` into counter i at the next clock edge and raises no zero event.
- R10: A load that coincides with a step on the same counter takes priority. The step's modify is discarded and no zero event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | Asynchronous line-frequency tick |
| tick_500 | input | 1 | Asynchronous 500 Hz tick |
| tick_2000 | input | 1 | Asynchronous 2000 Hz tick |
| ext_tick | input | 3 | Asynchronous external tick, one per selectable counter |
| src_sel | input | 6 | Source select, 2 bits per counter 0 to 2 |
| delta | input | 16 | Signed 4-bit modify value per counter |
| load_en | input | 4 | Load strobe per counter |
| load_val | input | 32 | Value to load |
| load_width | input | 2 | Operand width to load |
| pulse_irq | output | 4 | Count-pulse strobe per counter |
| zero_irq | output | 4 | Counter-equals-zero event per counter |
| cnt_value | output | 128 | Counter values, counter i at bits 32i+31:32i |

## Verification
The assertions check the following on every cycle:
- A load always lands as written and never produces a zero event.
- An idle counter holds its value.
- Zero events last one cycle, coincide with a count pulse, and match a zero field.
- Synchronized edges never repeat on consecutive cycles.

Several behaviours can only be shown by the bench scenarios. These are the source routing of each select code and the fixed source of counter 3. They also include byte and halfword wrap with the upper bits preserved, a single step per held tick, and the exact cycle on which a load collides with a step.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
    localparam int CNT_W   = 32;
    localparam int DELTA_W = 4;

    typedef enum logic [1:0] {
        WID_BYTE = 2'd0,
        WID_HALF = 2'd1,
        WID_WORD = 2'd2,
        WID_WALT = 2'd3
    } width_e;

    typedef enum logic [1:0] {
        SRC_LINE = 2'd0,
        SRC_500  = 2'd1,
        SRC_2000 = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        width_e           width;
    } cnt_state_t;

    function automatic logic [CNT_W-1:0] field_mask(width_e w);
        case (w)
            WID_BYTE: field_mask = CNT_W'(32'h0000_00FF);
            WID_HALF: field_mask = CNT_W'(32'h0000_FFFF);
            default:  field_mask = '1;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] apply_modify(logic [CNT_W-1:0] v,
                                                     logic [DELTA_W-1:0] d,
                                                     width_e w);
        logic [CNT_W-1:0] ext;
        logic [CNT_W-1:0] sum;
        logic [CNT_W-1:0] m;
        ext = {{(CNT_W-DELTA_W){d[DELTA_W-1]}}, d};
        sum = v + ext;
        m   = field_mask(w);
        apply_modify = (sum & m) | (v & ~m);
    endfunction

    function automatic logic field_is_zero(logic [CNT_W-1:0] v, width_e w);
        field_is_zero = ((v & field_mask(w)) == '0);
    endfunction
endpackage

// File: rtl/cpb_tick_sync.sv
module cpb_tick_sync #(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] raw,
    output logic [N_SRC-1:0] rise
);
    logic [N_SRC-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        AST_EDGE_GAP: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]); // R2
    end
endmodule

// File: rtl/cpb_counter.sv
module cpb_counter
    import cpb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [DELTA_W-1:0] delta,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  width_e             load_width,
    output logic [CNT_W-1:0]   value,
    output logic               pulse,
    output logic               zero
);
    cnt_state_t       st_q;
    logic [CNT_W-1:0] next_val;

    assign next_val = apply_modify(st_q.value, delta, st_q.width);
    assign value    = st_q.value;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.value <= '0;
            st_q.width <= WID_WORD;
            pulse      <= 1'b0;
            zero       <= 1'b0;
        end else begin
            pulse <= step;
            zero  <= 1'b0;
            if (load) begin
                st_q.value <= load_val;
                st_q.width <= load_width;
            end else if (step) begin
                st_q.value <= next_val;
                zero       <= field_is_zero(next_val, st_q.width);
            end
        end
    end

    AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (rst)
        load |=> value == $past(load_val)); // R9
    AST_LOAD_NO_ZERO: assert property (@(posedge clk) disable iff (rst)
        load |=> !zero); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(value)); // R2
    AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        zero |=> !zero); // R8
    AST_ZERO_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
        zero |-> pulse); // R5
    AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst)
        zero |-> field_is_zero(st_q.value, st_q.width)); // R8
endmodule

// File: rtl/cpb_bank.sv
module cpb_bank
    import cpb_pkg::*;
#(
    parameter int N_CNT = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_tick,
    input  logic                       tick_500,
    input  logic                       tick_2000,
    input  logic [N_CNT-2:0]           ext_tick,
    input  logic [2*(N_CNT-1)-1:0]     src_sel,
    input  logic [DELTA_W*N_CNT-1:0]   delta,
    input  logic [N_CNT-1:0]           load_en,
    input  logic [CNT_W-1:0]           load_val,
    input  logic [1:0]                 load_width,
    output logic [N_CNT-1:0]           pulse_irq,
    output logic [N_CNT-1:0]           zero_irq,
    output logic [CNT_W*N_CNT-1:0]     cnt_value
);
    localparam int N_SEL   = N_CNT - 1;
    localparam int N_SRC   = 3 + N_SEL;
    localparam int IDX_LN  = 0;
    localparam int IDX_500 = 1;
    localparam int IDX_2K  = 2;
    localparam int IDX_EXT = 3;

    logic [N_SRC-1:0] raw_src, rise;
    logic [N_CNT-1:0] step;

    assign raw_src = {ext_tick, tick_2000, tick_500, line_tick};

    cpb_tick_sync #(.N_SRC(N_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (raw_src),
        .rise(rise)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        if (i < N_SEL) begin : g_sel
            src_e sel;
            assign sel = src_e'(src_sel[2*i +: 2]);
            always_comb begin
                case (sel)
                    SRC_LINE: step[i] = rise[IDX_LN];
                    SRC_500:  step[i] = rise[IDX_500];
                    SRC_2000: step[i] = rise[IDX_2K];
                    default:  step[i] = rise[IDX_EXT + i];
                endcase
            end
        end else begin : g_fixed
            assign step[i] = rise[IDX_500];
        end

        cpb_counter u_cnt (
            .clk       (clk),
            .rst       (rst),
            .step      (step[i]),
            .delta     (delta[DELTA_W*i +: DELTA_W]),
            .load      (load_en[i]),
            .load_val  (load_val),
            .load_width(width_e'(load_width)),
            .value     (cnt_value[CNT_W*i +: CNT_W]),
            .pulse     (pulse_irq[i]),
            .zero      (zero_irq[i])
        );
    end
endmodule

// File: tb/cpb_bank_bench.sv
module cpb_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_tick = 0, tick_500 = 0, tick_2000 = 0;
    logic [2:0]  ext_tick = '0;
    logic [5:0]  src_sel = '0;
    logic [15:0] delta = '0;
    logic [3:0]  load_en = '0;
    logic [31:0] load_val = '0;
    logic [1:0]  load_width = '0;
    logic [3:0]  pulse_irq, zero_irq;
    logic [127:0] cnt_value;

    int checks = 0, errors = 0;
    int zc[4], pc[4];
    bit done = 0;

    always #2.5 clk = ~clk;

    cpb_bank u_cpb_bank (
        .clk(clk), .rst(rst), .line_tick(line_tick), .tick_500(tick_500),
        .tick_2000(tick_2000), .ext_tick(ext_tick), .src_sel(src_sel),
        .delta(delta), .load_en(load_en), .load_val(load_val),
        .load_width(load_width), .pulse_irq(pulse_irq), .zero_irq(zero_irq),
        .cnt_value(cnt_value)
    );

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                zc[i] += int'(zero_irq[i]);
                pc[i] += int'(pulse_irq[i]);
            end
        end
    end

    function automatic logic [31:0] val(int i);
        return cnt_value[32*i +: 32];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(int i, logic [31:0] v, logic [1:0] w);
        @(negedge clk);
        load_en = 4'(1 << i); load_val = v; load_width = w;
        @(negedge clk);
        load_en = '0;
    endtask

    // which: 0 line, 1 500, 2 2000, 3+j ext[j]
    task automatic tick(int which, int hold);
        @(negedge clk);
        case (which)
            0: line_tick = 1; 1: tick_500 = 1; 2: tick_2000 = 1;
            default: ext_tick[which-3] = 1;
        endcase
        repeat (hold) @(negedge clk);
        line_tick = 0; tick_500 = 0; tick_2000 = 0; ext_tick = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R1 value", val(i), 0);
        chk("R1 pulse", {28'd0, pulse_irq}, 0);
        chk("R1 zero", {28'd0, zero_irq}, 0);
    endtask

    task automatic t_load();
        int z0 = zc[0];
        do_load(0, 32'h1234_5678, 2'd2);
        chk("R9 load value", val(0), 32'h1234_5678);
        chk("R9 no zero on load", 32'(zc[0] - z0), 0);
        do_load(0, 32'h0, 2'd2);
        chk("R9 load zero value no event", 32'(zc[0] - z0), 0);
    endtask

    task automatic t_word();
        int z0 = zc[0], p0 = pc[0], z1 = zc[1];
        do_load(0, 32'd1, 2'd2);
        delta[3:0] = 4'hF;
        tick(0, 3);
        chk("R7 word decrement", val(0), 0);
        chk("R8 zero event c0", 32'(zc[0] - z0), 1);
        chk("R8 other counter quiet", 32'(zc[1] - z1), 0);
        chk("R5 pulse c0", 32'(pc[0] - p0), 1);
        tick(0, 3);
        chk("R7 word wrap", val(0), 32'hFFFF_FFFF);
    endtask

    task automatic t_hold();
        int p0 = pc[0];
        do_load(0, 32'd10, 2'd2);
        delta[3:0] = 4'd1;
        tick(0, 12);
        chk("R2 one step per held tick", val(0), 32'd11);
        chk("R5 one pulse per held tick", 32'(pc[0] - p0), 1);
    endtask

    task automatic t_latency();
        do_load(0, 32'd20, 2'd2);
        delta[3:0] = 4'd2;
        @(negedge clk); line_tick = 1;
        @(negedge clk); @(negedge clk);
        chk("R2 not yet updated", val(0), 32'd20);
        @(negedge clk);
        chk("R2 updated on third edge", val(0), 32'd22);
        chk("R5 pulse aligned", {31'd0, pulse_irq[0]}, 1);
        line_tick = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_byte();
        int z1 = zc[1], z3 = zc[3];
        do_load(1, 32'hABCD_FF01, 2'd0);
        do_load(3, 32'd0, 2'd2);
        delta[7:4] = 4'hF; delta[15:12] = 4'd3;
        tick(1, 3);
        chk("R6 byte decrement upper kept", val(1), 32'hABCD_FF00);
        chk("R8 zero with upper bits set", 32'(zc[1] - z1), 1);
        chk("R4 counter 3 on 500 Hz", val(3), 32'd3);
        chk("R8 counter 3 no zero", 32'(zc[3] - z3), 0);
        do_load(1, 32'h1122_33FF, 2'd0);
        delta[7:4] = 4'd1;
        tick(1, 3);
        chk("R6 byte wrap", val(1), 32'h1122_3300);
    endtask

    task automatic t_half();
        int z2 = zc[2];
        do_load(2, 32'h0001_FFFE, 2'd1);
        delta[11:8] = 4'd2;
        tick(2, 3);
        chk("R7 half wrap", val(2), 32'h0001_0000);
        chk("R8 half zero", 32'(zc[2] - z2), 1);
        do_load(2, 32'h0000_0005, 2'd3);
        delta[11:8] = 4'h8;
        tick(2, 3);
        chk("R6 code 3 acts as word", val(2), 32'hFFFF_FFFD);
    endtask

    task automatic t_ext();
        src_sel[1:0] = 2'd3;
        do_load(0, 32'd5, 2'd2);
        delta[3:0] = 4'd1;
        tick(0, 3);
        tick(4, 3);
        chk("R3 unselected ticks ignored", val(0), 32'd5);
        tick(3, 3);
        chk("R3 ext select", val(0), 32'd6);
        src_sel[1:0] = 2'd0;
    endtask

    task automatic t_c3_fixed();
        do_load(3, 32'd100, 2'd2);
        delta[15:12] = 4'd1;
        src_sel = 6'b11_11_11;
        tick(0, 3); tick(2, 3); tick(3, 3); tick(4, 3); tick(5, 3);
        chk("R4 counter 3 ignores other sources", val(3), 32'd100);
        tick(1, 3);
        chk("R4 counter 3 steps on 500 Hz", val(3), 32'd101);
        src_sel = 6'b10_01_00;
    endtask

    task automatic t_collide();
        int z2, p2;
        do_load(2, 32'h0000_0100, 2'd0);
        delta[11:8] = 4'd0;
        z2 = zc[2]; p2 = pc[2];
        @(negedge clk); tick_2000 = 1;
        @(negedge clk);
        @(negedge clk); load_en = 4'b0100; load_val = 32'd7; load_width = 2'd2;
        @(negedge clk); load_en = '0; tick_2000 = 0;
        repeat (4) @(negedge clk);
        chk("R10 load wins over step", val(2), 32'd7);
        chk("R10 no zero on collision", 32'(zc[2] - z2), 0);
        chk("R5 pulse still on collision", 32'(pc[2] - p2), 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst = 0;
        t_reset();
        src_sel = 6'b10_01_00;
        t_load();
        t_word();
        t_hold();
        t_latency();
        t_byte();
        t_half();
        t_ext();
        t_c3_fixed();
        t_collide();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule